// File: doc/BRIEF.md
# NAND Single-Bit Parity Code Engine

This block builds a 24-bit Hamming-style check code over a fixed-size block of flash data, 512 bytes by default, as the bytes stream in at one byte per valid cycle. Each data bit has a 12-bit address: the byte index in bits 11:3 and the bit position in bits 2:0. For every address bit there are two parity terms. The upper term collects the data ones whose address bit is 1, and the lower term collects the ones whose address bit is 0. When the last byte of a block arrives, the packed code is inverted, latched and announced, and the running sums clear for the next block. Because of the inversion, an erased page of all 0xFF bytes produces a code of all ones, which matches the code stored on an erased page.

The block also has a classification port. A code read back from the flash spare area is compared with the most recently latched code. The block reports one of four outcomes: no error, a single flipped data bit (with its byte and bit location), a single flipped code bit, or an error it cannot correct. Software or a downstream engine performs the actual bit flip. A restart input drops any partly accumulated block.

Top module: `nand_ecc1b_corrector`

## Requirements
- R1: The block accepts one byte on each cycle with `in_valid` high. On the clock edge that accepts byte number BLOCK_BYTES-1, `code_out` takes the new code, and `code_valid` is high for exactly the following cycle.
- R2: The upper parity half sits in `code_out[23:12]` and the lower half in `code_out[11:0]`. Bit k of a half is the parity of the data ones whose 12-bit address has bit k equal to 1 (upper half) or 0 (lower half). The complete 24-bit word is inverted. When the code is stored as three bytes, `code_out[7:0]` is the first byte.
- R3: A block of all 0xFF bytes produces the code 24'hFFFFFF.
- R4: Once a block completes, the accumulation restarts from zero, so the next block's code depends only on the next block's bytes.
- R5: A cycle with `restart` high and `in_valid` low discards the partial block. A cycle with both high discards it and takes that cycle's byte as byte 0 of a fresh block.
- R6: A `chk_req` gives `res_valid` high on the next cycle, and only then. If the stored code equals `code_out`, the status is CLEAN (2'd0).
- R7: Let diff = stored XOR `code_out`. If diff[23:12] XOR diff[11:0] equals 12'hFFF and diff[23:15] is below BLOCK_BYTES, the status is DATA_FIX (2'd1), `res_byte` = diff[23:15] and `res_bit` = diff[14:12].
- R8: The same fold pattern with diff[23:15] at or above BLOCK_BYTES gives UNCORR (2'd3).
- R9: A diff with exactly one bit set gives CODE_FIX (2'd2), and the location outputs are zero.
- R10: Any other nonzero diff gives UNCORR (2'd3) with zero location outputs.
- R11: During reset, `code_out` is 24'hFFFFFF, and `code_valid` and `res_valid` are low.
- R12: A comparison uses the `code_out` visible in the request cycle. A request made in the cycle that presents a block's last byte is therefore judged against the previous block's code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| restart | input | 1 | Discard the partial block |
| in_valid | input | 1 | A data byte is present |
| in_byte | input | 8 | Data byte |
| code_out | output | 24 | Latched inverted code of the last complete block |
| code_valid | output | 1 | One-cycle pulse when `code_out` is new |
| chk_req | input | 1 | Request a classification |
| chk_stored | input | 24 | Code read back from flash |
| res_valid | output | 1 | Classification result is valid |
| res_status | output | 2 | 0 clean, 1 data fix, 2 code fix, 3 uncorrectable |
| res_byte | output | 9 | Byte index to flip |
| res_bit | output | 3 | Bit position to flip |

## Verification
Two pairs of events can fall in the same cycle. The first is a classification request issued while the final byte of a block is being presented. The bench provokes it by giving that request the previous block's code, and it passes only if the result is CLEAN, which proves the old latched code was used. The second is a restart that coincides with a valid byte. The bench streams unrelated bytes first, then places block byte 0 on the restart cycle, and judges the result by whether the finished code equals the bench's own code for the intended block alone.

// File: rtl/ecc1b_pkg.sv
package ecc1b_pkg;

    localparam int HALF_W = 12;
    localparam int CODE_W = 2 * HALF_W;
    localparam int BIDX_W = 9;
    localparam int BPOS_W = 3;

    typedef enum logic [1:0] {
        ST_CLEAN    = 2'd0,
        ST_DATA_FIX = 2'd1,
        ST_CODE_FIX = 2'd2,
        ST_UNCORR   = 2'd3
    } ecc_status_e;

    // Parity contribution of one byte: {upper_half, lower_half}
    function automatic logic [CODE_W-1:0] byte_terms(
        input logic [BIDX_W-1:0] idx,
        input logic [7:0]        data
    );
        logic [HALF_W-1:0] up;
        logic [HALF_W-1:0] dn;
        logic [7:0]        sel;
        logic              par;
        par = ^data;
        for (int k = 0; k < BPOS_W; k++) begin
            for (int j = 0; j < 8; j++) begin
                sel[j] = ((j >> k) & 1) != 0;
            end
            up[k] = ^(data & sel);
            dn[k] = ^(data & ~sel);
        end
        for (int k = 0; k < BIDX_W; k++) begin
            up[k+BPOS_W] = par & idx[k];
            dn[k+BPOS_W] = par & ~idx[k];
        end
        return {up, dn};
    endfunction

    // Raw word carries one half in 11:0, the other in 27:16
    function automatic logic [CODE_W-1:0] pack_code(input logic [27:0] raw);
        return ~{raw[27:16], raw[11:0]};
    endfunction

endpackage

// File: rtl/ecc1b_accum.sv
module ecc1b_accum
    import ecc1b_pkg::*;
#(
    parameter int BLOCK_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid
);
    localparam int CNT_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BLOCK_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [HALF_W-1:0] up;
        logic [HALF_W-1:0] dn;
        logic [CODE_W-1:0] code;
        logic              done;
    } acc_s;

    acc_s acc_d, acc_q;

    logic [CNT_W-1:0]  base_cnt;
    logic [HALF_W-1:0] base_up, base_dn, new_up, new_dn;
    logic [CODE_W-1:0] terms;

    always_comb begin
        acc_d      = acc_q;
        acc_d.done = 1'b0;
        base_cnt   = restart ? '0 : acc_q.cnt;
        base_up    = restart ? '0 : acc_q.up;
        base_dn    = restart ? '0 : acc_q.dn;
        terms      = byte_terms(BIDX_W'(base_cnt), in_byte);
        new_up     = base_up ^ terms[CODE_W-1:HALF_W];
        new_dn     = base_dn ^ terms[HALF_W-1:0];
        acc_d.cnt  = base_cnt;
        acc_d.up   = base_up;
        acc_d.dn   = base_dn;
        if (in_valid) begin
            if (base_cnt == LAST_C) begin
                acc_d.code = pack_code({4'b0, new_up, 4'b0, new_dn});
                acc_d.done = 1'b1;
                acc_d.cnt  = '0;
                acc_d.up   = '0;
                acc_d.dn   = '0;
            end else begin
                acc_d.cnt  = base_cnt + 1'b1;
                acc_d.up   = new_up;
                acc_d.dn   = new_dn;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q      <= '0;
            acc_q.code <= '1;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign code_out   = acc_q.code;
    assign code_valid = acc_q.done;

    assert_pulse_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !restart && acc_q.cnt == LAST_C) |=> code_valid);
    assert_pulse_has_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> $past(in_valid));
    assert_code_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !code_valid |-> $stable(code_out));
    assert_clear_after_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> (acc_q.cnt == '0 && acc_q.up == '0 && acc_q.dn == '0));
    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !in_valid) |=> (acc_q.cnt == '0 && acc_q.up == '0 && acc_q.dn == '0));

endmodule

// File: rtl/ecc1b_classify.sv
module ecc1b_classify
    import ecc1b_pkg::*;
#(
    parameter int BLOCK_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_req,
    input  logic [CODE_W-1:0] stored,
    input  logic [CODE_W-1:0] calc,
    output logic              res_valid,
    output ecc_status_e       res_status,
    output logic [BIDX_W-1:0] res_byte,
    output logic [BPOS_W-1:0] res_bit
);
    typedef struct packed {
        logic              valid;
        ecc_status_e       status;
        logic [BIDX_W-1:0] byte_idx;
        logic [BPOS_W-1:0] bit_idx;
    } res_s;

    res_s res_d, res_q;

    logic [CODE_W-1:0] diff;
    logic [HALF_W-1:0] fold;

    always_comb begin
        res_d       = res_q;
        res_d.valid = chk_req;
        diff        = stored ^ calc;
        fold        = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
        if (chk_req) begin
            res_d.byte_idx = '0;
            res_d.bit_idx  = '0;
            if (diff == '0) begin
                res_d.status = ST_CLEAN;
            end else if (fold == '1) begin
                if (int'(diff[CODE_W-1:CODE_W-BIDX_W]) < BLOCK_BYTES) begin
                    res_d.status   = ST_DATA_FIX;
                    res_d.byte_idx = diff[CODE_W-1:CODE_W-BIDX_W];
                    res_d.bit_idx  = diff[HALF_W+BPOS_W-1:HALF_W];
                end else begin
                    res_d.status = ST_UNCORR;
                end
            end else if ($onehot(diff)) begin
                res_d.status = ST_CODE_FIX;
            end else begin
                res_d.status = ST_UNCORR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid  = res_q.valid;
    assign res_status = res_q.status;
    assign res_byte   = res_q.byte_idx;
    assign res_bit    = res_q.bit_idx;

    assert_result_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> res_valid);
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_req |=> !res_valid);
    assert_clean_iff_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req |=> ((res_status == ST_CLEAN) == ($past(stored) == $past(calc))));
    assert_loc_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == ST_DATA_FIX) |-> (int'(res_byte) < BLOCK_BYTES));
    assert_loc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status != ST_DATA_FIX) |-> (res_byte == '0 && res_bit == '0));

endmodule

// File: rtl/nand_ecc1b_corrector.sv
module nand_ecc1b_corrector
    import ecc1b_pkg::*;
#(
    parameter int BLOCK_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic [23:0] code_out,
    output logic        code_valid,
    input  logic        chk_req,
    input  logic [23:0] chk_stored,
    output logic        res_valid,
    output logic [1:0]  res_status,
    output logic [8:0]  res_byte,
    output logic [2:0]  res_bit
);
    ecc_status_e status_w;

    ecc1b_accum #(.BLOCK_BYTES(BLOCK_BYTES)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .code_out   (code_out),
        .code_valid (code_valid)
    );

    ecc1b_classify #(.BLOCK_BYTES(BLOCK_BYTES)) u_classify (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_req    (chk_req),
        .stored     (chk_stored),
        .calc       (code_out),
        .res_valid  (res_valid),
        .res_status (status_w),
        .res_byte   (res_byte),
        .res_bit    (res_bit)
    );

    assign res_status = status_w;

endmodule

// File: tb/nand_ecc1b_corrector_bench.sv
module nand_ecc1b_corrector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 512;

    logic clk = 0;
    logic rst_n = 0;
    logic restart = 0, in_valid = 0, chk_req = 0;
    logic [7:0] in_byte = 0;
    logic [23:0] chk_stored = 0;
    logic [23:0] code_out;
    logic code_valid, res_valid;
    logic [1:0] res_status;
    logic [8:0] res_byte;
    logic [2:0] res_bit;

    // second instance with a short block, used for the range rule
    logic chk2 = 0;
    logic [23:0] st2 = 0;
    logic [23:0] code2;
    logic cv2, rv2;
    logic [1:0] rs2;
    logic [8:0] rb2;
    logic [2:0] rbit2;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_ecc1b_corrector u_nand_ecc1b_corrector (
        .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
        .in_byte(in_byte), .code_out(code_out), .code_valid(code_valid),
        .chk_req(chk_req), .chk_stored(chk_stored), .res_valid(res_valid),
        .res_status(res_status), .res_byte(res_byte), .res_bit(res_bit));

    nand_ecc1b_corrector #(.BLOCK_BYTES(256)) u_short (
        .clk(clk), .rst_n(rst_n), .restart(1'b0), .in_valid(1'b0),
        .in_byte(8'h00), .code_out(code2), .code_valid(cv2),
        .chk_req(chk2), .chk_stored(st2), .res_valid(rv2),
        .res_status(rs2), .res_byte(rb2), .res_bit(rbit2));

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [0:NB-1];

    typedef struct {
        logic [23:0] code;
        string       tag;
    } exp_code_t;
    typedef struct {
        logic [1:0] st;
        logic [8:0] by;
        logic [2:0] bi;
        string      tag;
    } exp_res_t;
    exp_code_t code_q[$];
    exp_res_t  res_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_code();
        logic [11:0] up;
        logic [11:0] dn;
        logic [11:0] a;
        up = '0;
        dn = '0;
        for (int i = 0; i < NB; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem[i][b]) begin
                    a = 12'(i * 8 + b);
                    for (int k = 0; k < 12; k++) begin
                        if (a[k]) up[k] = ~up[k];
                        else      dn[k] = ~dn[k];
                    end
                end
            end
        end
        return ~{up, dn};
    endfunction

    // monitor: compare results as they appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (code_valid) begin
                if (code_q.size() == 0) check(0, "R1", "unexpected code_valid", 1, 0);
                else begin
                    exp_code_t e;
                    e = code_q.pop_front();
                    check(code_out == e.code, e.tag, "code_out", code_out, e.code);
                end
            end
            if (res_valid) begin
                if (res_q.size() == 0) check(0, "R6", "unexpected res_valid", 1, 0);
                else begin
                    exp_res_t r;
                    r = res_q.pop_front();
                    check(res_status == r.st, r.tag, "res_status", res_status, r.st);
                    check(res_byte == r.by && res_bit == r.bi, r.tag, "location",
                          {res_byte, res_bit}, {r.by, r.bi});
                end
            end
        end
    end

    task automatic drive(input logic v, input logic [7:0] b, input logic rs,
                         input logic ck, input logic [23:0] st);
        @(negedge clk);
        in_valid   = v;
        in_byte    = b;
        restart    = rs;
        chk_req    = ck;
        chk_stored = st;
    endtask

    task automatic expect_res(input logic [1:0] st, input logic [8:0] by,
                              input logic [2:0] bi, input string tag);
        exp_res_t r;
        r.st = st; r.by = by; r.bi = bi; r.tag = tag;
        res_q.push_back(r);
    endtask

    // streams mem; optional request on the last byte and in the pulse cycle
    task automatic run_block(input string tag, input bit ck_last, input logic [23:0] st_last,
                             input bit ck_after, input logic [23:0] st_after);
        exp_code_t e;
        e.code = ref_code();
        e.tag  = tag;
        code_q.push_back(e);
        for (int i = 0; i < NB - 1; i++) drive(1, mem[i], 0, 0, 24'h0);
        if (ck_last) expect_res(2'd0, 9'd0, 3'd0, "R12");
        drive(1, mem[NB-1], 0, ck_last, st_last);
        if (ck_after) expect_res(2'd0, 9'd0, 3'd0, "R12");
        drive(0, 8'h00, 0, ck_after, st_after);
        check(code_valid == 1'b1, "R1", "pulse one cycle after last byte", code_valid, 1);
        drive(0, 8'h00, 0, 0, 24'h0);
        check(code_valid == 1'b0, "R1", "pulse lasts one cycle", code_valid, 0);
    endtask

    task automatic fill_lcg(input int unsigned seed);
        int unsigned s;
        s = seed;
        for (int i = 0; i < NB; i++) begin
            s = s * 1103515245 + 12345;
            mem[i] = s[23:16];
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        check(0, "R1", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [23:0] prev, cur, st;
        logic [11:0] a;
        repeat (3) @(negedge clk);
        check(code_out == 24'hFFFFFF, "R11", "reset code_out", code_out, 24'hFFFFFF);
        check(code_valid == 1'b0, "R11", "reset code_valid", code_valid, 0);
        check(res_valid == 1'b0, "R11", "reset res_valid", res_valid, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R3 erased block
        for (int i = 0; i < NB; i++) mem[i] = 8'hFF;
        run_block("R3", 0, 0, 0, 0);
        check(code_out == 24'hFFFFFF, "R3", "erased code", code_out, 24'hFFFFFF);

        // R2 pseudo-random data, then sparse data
        fill_lcg(32'h1234);
        run_block("R2", 0, 0, 0, 0);
        for (int i = 0; i < NB; i++) mem[i] = 8'h00;
        mem[0] = 8'h01; mem[300] = 8'h40; mem[511] = 8'h80;
        run_block("R2", 0, 0, 0, 0);

        // R4 back-to-back block with independent code; R12 same-cycle request
        prev = code_out;
        fill_lcg(32'hBEEF);
        cur = ref_code();
        run_block("R4", 1, prev, 1, cur);

        // R5 restart without data mid-stream
        for (int i = 0; i < 50; i++) drive(1, 8'(i * 7 + 3), 0, 0, 24'h0);
        drive(0, 8'h00, 1, 0, 24'h0);
        fill_lcg(32'h0042);
        run_block("R5", 0, 0, 0, 0);

        // R5 restart together with byte 0
        for (int i = 0; i < 100; i++) drive(1, 8'(i ^ 8'h5A), 0, 0, 24'h0);
        fill_lcg(32'h7777);
        begin
            exp_code_t e;
            e.code = ref_code();
            e.tag  = "R5";
            code_q.push_back(e);
            drive(1, mem[0], 1, 0, 24'h0);
            for (int i = 1; i < NB; i++) drive(1, mem[i], 0, 0, 24'h0);
            drive(0, 8'h00, 0, 0, 24'h0);
            check(code_valid == 1'b1, "R5", "pulse after restart block", code_valid, 1);
        end
        cur = code_out;

        // R6 clean compare
        expect_res(2'd0, 9'd0, 3'd0, "R6");
        drive(0, 8'h00, 0, 1, cur);
        // R7 data-bit errors from corrupted data
        mem[37] ^= 8'h20; st = ref_code(); mem[37] ^= 8'h20;
        expect_res(2'd1, 9'd37, 3'd5, "R7");
        drive(0, 8'h00, 0, 1, st);
        mem[511] ^= 8'h80; st = ref_code(); mem[511] ^= 8'h80;
        expect_res(2'd1, 9'd511, 3'd7, "R7");
        drive(0, 8'h00, 0, 1, st);
        mem[0] ^= 8'h01; st = ref_code(); mem[0] ^= 8'h01;
        expect_res(2'd1, 9'd0, 3'd0, "R7");
        drive(0, 8'h00, 0, 1, st);
        // R9 single code bit
        expect_res(2'd2, 9'd0, 3'd0, "R9");
        drive(0, 8'h00, 0, 1, cur ^ 24'h000080);
        expect_res(2'd2, 9'd0, 3'd0, "R9");
        drive(0, 8'h00, 0, 1, cur ^ 24'h100000);
        // R10 two code bits, two data bits
        expect_res(2'd3, 9'd0, 3'd0, "R10");
        drive(0, 8'h00, 0, 1, cur ^ 24'h000003);
        mem[10] ^= 8'h02; mem[200] ^= 8'h10; st = ref_code();
        mem[10] ^= 8'h02; mem[200] ^= 8'h10;
        expect_res(2'd3, 9'd0, 3'd0, "R10");
        drive(0, 8'h00, 0, 1, st);
        drive(0, 8'h00, 0, 0, 24'h0);
        drive(0, 8'h00, 0, 0, 24'h0);

        // R8 with 256-byte block: index 300 out of range, 200 in range
        a = 12'(300 * 8 + 2);
        @(negedge clk); chk2 = 1; st2 = 24'hFFFFFF ^ {a, ~a};
        @(negedge clk); chk2 = 0;
        check(rv2 == 1'b1 && rs2 == 2'd3, "R8", "out-of-range index", {rv2, rs2}, {1'b1, 2'd3});
        a = 12'(200 * 8 + 6);
        chk2 = 1; st2 = 24'hFFFFFF ^ {a, ~a};
        @(negedge clk); chk2 = 0;
        check(rs2 == 2'd1 && rb2 == 9'd200 && rbit2 == 3'd6, "R8", "in-range index",
              {rs2, rb2, rbit2}, {2'd1, 9'd200, 3'd6});

        repeat (3) @(negedge clk);
        check(code_q.size() == 0, "R1", "pending codes", code_q.size(), 0);
        check(res_q.size() == 0, "R6", "pending results", res_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule